// File: doc/BRIEF.md
# Flash Write Suspend and Resume Controller

This block holds the operation state of a serial flash array while a host interrupts and continues long write operations. It receives already decoded command strobes (suspend, resume, program, sector erase, block erase, chip erase, read) with a byte address, a one-microsecond tick, and a done pulse from the array timing model. From these it decides, cycle by cycle, whether each command is taken or dropped. It drives the busy status, an erase-suspended flag and a program-suspended flag.

A running sector erase, block erase or page program can be parked, with the suspended address range remembered. While it is parked, one more write may run elsewhere in the array. Reads inside a parked erase range are marked as returning undefined data, and writes into that range are refused. Only one operation can be parked at a time. A chip erase can never be parked. Successive suspends are held apart by a minimum number of microsecond ticks. Resume continues the parked operation once any nested write has finished.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: During and right after reset, busy_o, erase_susp_o, prog_susp_o, cmd_ok_o, cmd_drop_o and rd_undef_o are all 0.
- R2: Every command strobe gets exactly one of cmd_ok_o or cmd_drop_o, as a registered pulse in the cycle after the strobe. When idle, a read is taken with busy_o left low. A program, sector erase, block erase or chip erase is taken, and busy_o is high from the next cycle until the cycle after op_done_i.
- R3: A suspend during a running program, sector erase or block erase is taken if the spacing rule allows it. In the next cycle prog_susp_o (for a program) or erase_susp_o (for an erase) is 1. busy_o stays high for SUSP_LAT_CYC cycles after the suspend edge and then drops.
- R4: A suspend while idle or during a chip erase is dropped and sets no flag. A suspend dropped while idle does not restart the spacing count.
- R5: A suspend is dropped while an operation is parked, whether or not a nested write is running.
- R6: A suspend is dropped while fewer than MIN_GAP_US ticks of us_tick_i have been seen since the last taken suspend.
- R7: While an operation is parked, a chip erase is dropped.
- R8: While an erase is parked, a program or erase whose range overlaps the parked range is dropped. Pages are 2^PAGE_W bytes, sectors 2^SECTOR_W bytes and blocks 2^BLOCK_W bytes, aligned. A non-overlapping write is taken and keeps busy_o high until op_done_i.
- R9: While parked, a read is taken. rd_undef_o is 1 with cmd_ok_o only when an erase is parked and the address lies in its range. Otherwise it is 0.
- R10: Resume is dropped while a nested write runs, including in the cycle where that write's op_done_i arrives. When parked and idle, resume is taken: the suspend flag clears and busy_o is high from the next cycle. A later op_done_i ends the resumed operation.
- R11: op_done_i has no effect while an operation is parked: busy_o stays low and the flag stays set.
- R12: If op_done_i and a suspend arrive in the same cycle of a running operation, the operation ends, the suspend is dropped, no flag is set, and the spacing count is not restarted.
- R13: While busy with a running or nested operation, every command other than a qualifying suspend is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| suspend_i | input | 1 | Suspend command strobe |
| resume_i | input | 1 | Resume command strobe |
| chip_erase_i | input | 1 | Chip erase command strobe |
| program_i | input | 1 | Page program command strobe |
| sector_erase_i | input | 1 | Sector erase command strobe |
| block_erase_i | input | 1 | Block erase command strobe |
| read_i | input | 1 | Read command strobe |
| addr_i | input | ADDR_W | Target byte address of the command |
| op_done_i | input | 1 | Active array operation has completed |
| busy_o | output | 1 | Busy status |
| erase_susp_o | output | 1 | An erase is parked |
| prog_susp_o | output | 1 | A program is parked |
| cmd_ok_o | output | 1 | Previous-cycle command was taken |
| cmd_drop_o | output | 1 | Previous-cycle command was ignored |
| rd_undef_o | output | 1 | Taken read hits a parked erase range |

## Verification
The two functions that can fall in the same cycle are the completion of the running operation and a request to leave that operation's state. One case is a suspend arriving together with op_done_i while running. The other is a resume arriving together with a nested write's op_done_i. The bench raises both strobes in the same cycle. It then judges the outcome at the ports: busy_o, the flags and the drop pulse must match the stated precedence. A suspend issued right afterwards must still be taken, which shows the spacing count was not restarted.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_SECT, OP_BLOCK, OP_CHIP, OP_READ
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_HALT, ST_SUSP, ST_NEST
  } st_e;
endpackage

// File: rtl/fsc_cmd_dec.sv
module fsc_cmd_dec
  import fsc_pkg::*;
(
  input  logic suspend_i,
  input  logic resume_i,
  input  logic chip_erase_i,
  input  logic program_i,
  input  logic sector_erase_i,
  input  logic block_erase_i,
  input  logic read_i,
  output logic is_sus_o,
  output logic is_res_o,
  output logic any_o,
  output op_e  op_o
);
  // fixed priority if the decoder upstream ever raises two strobes
  always_comb begin
    is_sus_o = suspend_i;
    is_res_o = resume_i & ~suspend_i;
    op_o     = OP_NONE;
    if (!suspend_i && !resume_i) begin
      if (chip_erase_i)        op_o = OP_CHIP;
      else if (block_erase_i)  op_o = OP_BLOCK;
      else if (sector_erase_i) op_o = OP_SECT;
      else if (program_i)      op_o = OP_PROG;
      else if (read_i)         op_o = OP_READ;
    end
    any_o = suspend_i | resume_i | chip_erase_i | program_i |
            sector_erase_i | block_erase_i | read_i;
  end
endmodule

// File: rtl/fsc_range.sv
module fsc_range
  import fsc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int PAGE_W   = 8,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 16
) (
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  localparam logic [ADDR_W-1:0] PG_M = ADDR_W'((64'd1 << PAGE_W) - 64'd1);
  localparam logic [ADDR_W-1:0] SC_M = ADDR_W'((64'd1 << SECTOR_W) - 64'd1);
  localparam logic [ADDR_W-1:0] BK_M = ADDR_W'((64'd1 << BLOCK_W) - 64'd1);

  logic [ADDR_W-1:0] mask;

  always_comb begin
    unique case (op_i)
      OP_PROG:  mask = PG_M;
      OP_SECT:  mask = SC_M;
      OP_BLOCK: mask = BK_M;
      OP_CHIP:  mask = '1;
      default:  mask = '0;
    endcase
    lo_o = addr_i & ~mask;
    hi_o = addr_i | mask;
  end
endmodule

// File: rtl/fsc_gap_timer.sv
module fsc_gap_timer #(
  parameter int MIN_GAP_US = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clear_i,
  output logic ok_o
);
  localparam int CW = $clog2(MIN_GAP_US + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_GAP_US);

  logic [CW-1:0] cnt_q;

  // starts saturated so the first suspend after reset is allowed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= LIMIT;
    else if (clear_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q >= LIMIT);
endmodule

// File: rtl/fsc_lat_timer.sv
module fsc_lat_timer #(
  parameter int LAT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl
  import fsc_pkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int PAGE_W       = 8,
  parameter int SECTOR_W     = 12,
  parameter int BLOCK_W      = 16,
  parameter int MIN_GAP_US   = 500,
  parameter int SUSP_LAT_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              us_tick_i,
  input  logic              suspend_i,
  input  logic              resume_i,
  input  logic              chip_erase_i,
  input  logic              program_i,
  input  logic              sector_erase_i,
  input  logic              block_erase_i,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              op_done_i,
  output logic              busy_o,
  output logic              erase_susp_o,
  output logic              prog_susp_o,
  output logic              cmd_ok_o,
  output logic              cmd_drop_o,
  output logic              rd_undef_o
);
  st_e  st_q, st_d;
  op_e  cmd_op, prim_op_q;
  logic is_sus, is_res, any_cmd, is_write;
  logic [ADDR_W-1:0] in_lo, in_hi, prim_lo_q, prim_hi_q;
  logic gap_ok, lat_exp, overlap, parked_erase;
  logic ok_d, drop_d, undef_d, start_prim, sus_acc, res_acc;
  logic esus_q, psus_q, ok_q, drop_q, undef_q;

  fsc_cmd_dec u_dec (
    .suspend_i      (suspend_i),
    .resume_i       (resume_i),
    .chip_erase_i   (chip_erase_i),
    .program_i      (program_i),
    .sector_erase_i (sector_erase_i),
    .block_erase_i  (block_erase_i),
    .read_i         (read_i),
    .is_sus_o       (is_sus),
    .is_res_o       (is_res),
    .any_o          (any_cmd),
    .op_o           (cmd_op)
  );

  fsc_range #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W)
  ) u_range (
    .op_i   (cmd_op),
    .addr_i (addr_i),
    .lo_o   (in_lo),
    .hi_o   (in_hi)
  );

  fsc_gap_timer #(.MIN_GAP_US(MIN_GAP_US)) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (us_tick_i),
    .clear_i (sus_acc),
    .ok_o    (gap_ok)
  );

  fsc_lat_timer #(.LAT(SUSP_LAT_CYC)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (sus_acc),
    .expired_o (lat_exp)
  );

  assign is_write     = (cmd_op == OP_PROG) || (cmd_op == OP_SECT) ||
                        (cmd_op == OP_BLOCK) || (cmd_op == OP_CHIP);
  assign overlap      = (in_lo <= prim_hi_q) && (in_hi >= prim_lo_q);
  assign parked_erase = (prim_op_q == OP_SECT) || (prim_op_q == OP_BLOCK);

  always_comb begin
    st_d       = st_q;
    ok_d       = 1'b0;
    drop_d     = 1'b0;
    undef_d    = 1'b0;
    start_prim = 1'b0;
    sus_acc    = 1'b0;
    res_acc    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (is_sus || is_res) drop_d = 1'b1;
        else if (is_write) begin
          ok_d       = 1'b1;
          start_prim = 1'b1;
          st_d       = ST_RUN;
        end else if (cmd_op == OP_READ) ok_d = 1'b1;
      end
      ST_RUN: begin
        // completion wins over a same-cycle suspend
        if (op_done_i) begin
          st_d   = ST_IDLE;
          drop_d = any_cmd;
        end else if (is_sus && prim_op_q != OP_CHIP && gap_ok) begin
          ok_d    = 1'b1;
          sus_acc = 1'b1;
          st_d    = ST_HALT;
        end else drop_d = any_cmd;
      end
      ST_HALT: begin
        if (lat_exp) st_d = ST_SUSP;
        drop_d = any_cmd;
      end
      ST_SUSP: begin
        if (is_sus) drop_d = 1'b1;
        else if (is_res) begin
          ok_d    = 1'b1;
          res_acc = 1'b1;
          st_d    = ST_RUN;
        end else if (cmd_op == OP_CHIP) drop_d = 1'b1;
        else if (is_write) begin
          if (parked_erase && overlap) drop_d = 1'b1;
          else begin
            ok_d = 1'b1;
            st_d = ST_NEST;
          end
        end else if (cmd_op == OP_READ) begin
          ok_d    = 1'b1;
          undef_d = parked_erase && overlap;
        end
      end
      ST_NEST: begin
        if (op_done_i) st_d = ST_SUSP;
        drop_d = any_cmd;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      prim_op_q <= OP_NONE;
      prim_lo_q <= '0;
      prim_hi_q <= '0;
      esus_q    <= 1'b0;
      psus_q    <= 1'b0;
      ok_q      <= 1'b0;
      drop_q    <= 1'b0;
      undef_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      ok_q    <= ok_d;
      drop_q  <= drop_d;
      undef_q <= undef_d;
      if (start_prim) begin
        prim_op_q <= cmd_op;
        prim_lo_q <= in_lo;
        prim_hi_q <= in_hi;
      end
      if (sus_acc) begin
        esus_q <= parked_erase;
        psus_q <= (prim_op_q == OP_PROG);
      end else if (res_acc) begin
        esus_q <= 1'b0;
        psus_q <= 1'b0;
      end
    end
  end

  assign busy_o       = (st_q == ST_RUN) || (st_q == ST_HALT) || (st_q == ST_NEST);
  assign erase_susp_o = esus_q;
  assign prog_susp_o  = psus_q;
  assign cmd_ok_o     = ok_q;
  assign cmd_drop_o   = drop_q;
  assign rd_undef_o   = undef_q;
endmodule

// File: rtl/fsc_chk.sv
module fsc_chk #(
  parameter int MIN_GAP_US = 500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic us_tick_i,
  input logic suspend_i,
  input logic resume_i,
  input logic busy_o,
  input logic erase_susp_o,
  input logic prog_susp_o,
  input logic cmd_ok_o,
  input logic cmd_drop_o,
  input logic rd_undef_o
);
  localparam int CW = $clog2(MIN_GAP_US + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_GAP_US);

  logic          flag, prev_q, seen_q, rise;
  logic [CW-1:0] gcnt_q;

  assign flag = erase_susp_o | prog_susp_o;
  assign rise = flag & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      gcnt_q <= '0;
    end else begin
      prev_q <= flag;
      if (rise) begin
        seen_q <= 1'b1;
        gcnt_q <= us_tick_i ? CW'(1) : '0;
      end else if (us_tick_i && gcnt_q < LIMIT) begin
        gcnt_q <= gcnt_q + 1'b1;
      end
    end
  end

  // R2
  ok_drop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_ok_o && cmd_drop_o));

  // R3
  one_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({erase_susp_o, prog_susp_o}));

  // R3
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |-> busy_o && cmd_ok_o && $past(suspend_i));

  // R10
  flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag && prev_q) |-> busy_o && cmd_ok_o && $past(resume_i));

  // R9
  undef_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_undef_o |-> erase_susp_o && cmd_ok_o);

  // R6
  gap_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |-> (!seen_q || gcnt_q >= LIMIT));
endmodule

bind flash_suspend_ctrl fsc_chk #(.MIN_GAP_US(MIN_GAP_US)) u_fsc_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .us_tick_i    (us_tick_i),
  .suspend_i    (suspend_i),
  .resume_i     (resume_i),
  .busy_o       (busy_o),
  .erase_susp_o (erase_susp_o),
  .prog_susp_o  (prog_susp_o),
  .cmd_ok_o     (cmd_ok_o),
  .cmd_drop_o   (cmd_drop_o),
  .rd_undef_o   (rd_undef_o)
);

// File: tb/flash_suspend_ctrl_bench.sv
module flash_suspend_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 12;
  localparam int PW  = 4;
  localparam int SW  = 6;
  localparam int BW  = 8;
  localparam int GAP = 5;
  localparam int LAT = 3;

  localparam int C_SUS = 0, C_RES = 1, C_CHIP = 2, C_PROG = 3,
                 C_SECT = 4, C_BLK = 5, C_READ = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sus = 1'b0, res = 1'b0, che = 1'b0, pgm = 1'b0;
  logic ser = 1'b0, ber = 1'b0, rd = 1'b0, done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic busy, esus, psus, ok, drop, undef;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_suspend_ctrl #(
    .ADDR_W(AW), .PAGE_W(PW), .SECTOR_W(SW), .BLOCK_W(BW),
    .MIN_GAP_US(GAP), .SUSP_LAT_CYC(LAT)
  ) u_flash_suspend_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick),
    .suspend_i(sus), .resume_i(res), .chip_erase_i(che), .program_i(pgm),
    .sector_erase_i(ser), .block_erase_i(ber), .read_i(rd),
    .addr_i(addr), .op_done_i(done),
    .busy_o(busy), .erase_susp_o(esus), .prog_susp_o(psus),
    .cmd_ok_o(ok), .cmd_drop_o(drop), .rd_undef_o(undef)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic send(input int k, input int a);
    addr = AW'(a);
    case (k)
      C_SUS:   sus = 1'b1;
      C_RES:   res = 1'b1;
      C_CHIP:  che = 1'b1;
      C_PROG:  pgm = 1'b1;
      C_SECT:  ser = 1'b1;
      C_BLK:   ber = 1'b1;
      default: rd  = 1'b1;
    endcase
    @(negedge clk);
    {sus, res, che, pgm, ser, ber, rd} = '0;
  endtask

  task automatic resp(input string req, input int exp_ok);
    chk(req, "cmd_ok", int'(ok), exp_ok);
    chk(req, "cmd_drop", int'(drop), 1 - exp_ok);
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic wait_lat();
    repeat (LAT) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    repeat (3) step();
    // R1
    chk("R1", "busy in reset", int'(busy), 0);
    chk("R1", "flags in reset", int'({esus, psus}), 0);
    chk("R1", "resp in reset", int'({ok, drop, undef}), 0);
    rst_n = 1'b1;
    step();
    chk("R1", "outputs after reset", int'({busy, esus, psus, ok, drop, undef}), 0);

    // R2 idle read and program
    send(C_READ, 'h10); resp("R2", 1); chk("R2", "busy after read", int'(busy), 0);
    send(C_PROG, 'h20); resp("R2", 1); chk("R2", "busy after program", int'(busy), 1);
    repeat (4) step();
    chk("R2", "busy held", int'(busy), 1);
    // R13 commands while busy
    send(C_SECT, 'h40); resp("R13", 0);
    send(C_RES, 0);     resp("R13", 0);
    send(C_READ, 0);    resp("R13", 0);
    pulse_done(); chk("R2", "busy after done", int'(busy), 0);
    step(); chk("R2", "no pulse without cmd", int'({ok, drop}), 0);

    // R4 idle suspend and chip-erase suspend
    send(C_SUS, 0); resp("R4", 0); chk("R4", "flags idle", int'({esus, psus}), 0);
    send(C_CHIP, 0); resp("R2", 1);
    tick_n(GAP);
    send(C_SUS, 0); resp("R4", 0);
    chk("R4", "flags chip", int'({esus, psus}), 0);
    chk("R4", "busy chip", int'(busy), 1);
    pulse_done(); chk("R2", "chip done", int'(busy), 0);

    // R3 erase suspend latency
    send(C_SECT, 'h140); resp("R2", 1);
    send(C_SUS, 0); resp("R3", 1);
    chk("R3", "erase flag", int'(esus), 1);
    chk("R3", "prog flag", int'(psus), 0);
    for (int i = 1; i < LAT; i++) begin
      step(); chk("R3", "busy in latency", int'(busy), 1);
    end
    step(); chk("R3", "busy after latency", int'(busy), 0);
    chk("R3", "erase flag held", int'(esus), 1);

    send(C_SUS, 0);  resp("R5", 0);
    send(C_CHIP, 0); resp("R7", 0); chk("R7", "busy", int'(busy), 0);
    pulse_done();
    chk("R11", "busy after stray done", int'(busy), 0);
    chk("R11", "flag after stray done", int'(esus), 1);

    // R10 nested write and resume rules
    send(C_PROG, 'h000); resp("R8", 1); chk("R8", "nested busy", int'(busy), 1);
    send(C_RES, 0); resp("R10", 0); chk("R10", "flag kept", int'(esus), 1);
    send(C_SUS, 0); resp("R5", 0);
    res = 1'b1; done = 1'b1; step(); res = 1'b0; done = 1'b0;
    resp("R10", 0);
    chk("R10", "busy after nested done", int'(busy), 0);
    chk("R10", "flag after nested done", int'(esus), 1);
    send(C_RES, 0); resp("R10", 1);
    chk("R10", "flag cleared", int'(esus), 0);
    chk("R10", "busy resumed", int'(busy), 1);
    pulse_done(); chk("R10", "resumed op ends", int'(busy), 0);

    // R6 spacing, R4 idle suspend does not restart
    tick_n(GAP - 1);
    send(C_SUS, 0); resp("R4", 0);
    send(C_SECT, 0); resp("R2", 1);
    send(C_SUS, 0); resp("R6", 0); chk("R6", "no flag", int'(esus), 0);
    tick_n(1);
    send(C_SUS, 0); resp("R4", 1); chk("R4", "flag after gap", int'(esus), 1);
    wait_lat();
    send(C_RES, 0); resp("R10", 1);
    pulse_done();

    // R12 done and suspend together
    tick_n(GAP);
    send(C_PROG, 'h30); resp("R2", 1);
    sus = 1'b1; done = 1'b1; step(); sus = 1'b0; done = 1'b0;
    resp("R12", 0);
    chk("R12", "busy", int'(busy), 0);
    chk("R12", "flags", int'({esus, psus}), 0);
    send(C_SECT, 'h80); resp("R2", 1);
    send(C_SUS, 0); resp("R12", 1); chk("R12", "gap not restarted", int'(esus), 1);
    wait_lat();
    send(C_RES, 0); resp("R10", 1);
    pulse_done();

    // R3 / R9 program suspend
    tick_n(GAP);
    send(C_PROG, 'h150); resp("R2", 1);
    send(C_SUS, 0); resp("R3", 1);
    chk("R3", "prog flag", int'(psus), 1);
    chk("R3", "erase flag", int'(esus), 0);
    wait_lat();
    send(C_READ, 'h155); resp("R9", 1); chk("R9", "undef on prog park", int'(undef), 0);
    send(C_PROG, 'h150); resp("R8", 1);
    pulse_done();
    send(C_RES, 0); resp("R10", 1);
    pulse_done();

    // R8 / R9 sweep over all pages with sector 5 parked
    tick_n(GAP);
    send(C_SECT, 'h147); resp("R2", 1);
    send(C_SUS, 0); resp("R3", 1);
    wait_lat();
    for (int p = 0; p < (1 << (AW - PW)); p++) begin
      automatic int hit = ((p >> (SW - PW)) == 5) ? 1 : 0;
      send(C_READ, p * (1 << PW) + 3);
      resp("R9", 1);
      chk("R9", "undef", int'(undef), hit);
      send(C_PROG, p * (1 << PW));
      resp("R8", 1 - hit);
      if (hit == 0) begin
        chk("R8", "nested busy", int'(busy), 1);
        pulse_done();
        chk("R8", "nested done", int'(busy), 0);
        chk("R8", "flag kept", int'(esus), 1);
      end
    end
    send(C_RES, 0); resp("R10", 1);
    pulse_done();

    // R8 / R9 sweep over all sectors with block 2 parked
    tick_n(GAP);
    send(C_BLK, 'h2A0); resp("R2", 1);
    send(C_SUS, 0); resp("R3", 1);
    wait_lat();
    send(C_READ, 'h2FF); resp("R9", 1); chk("R9", "undef block end", int'(undef), 1);
    send(C_READ, 'h300); resp("R9", 1); chk("R9", "undef past block", int'(undef), 0);
    for (int s = 0; s < (1 << (AW - SW)); s++) begin
      automatic int hit = ((s >> (BW - SW)) == 2) ? 1 : 0;
      send(C_SECT, s * (1 << SW) + 5);
      resp("R8", 1 - hit);
      if (hit == 0) pulse_done();
    end
    send(C_RES, 0); resp("R10", 1);
    pulse_done();
    chk("R10", "idle at end", int'({busy, esus, psus}), 0);

    report();
  end
endmodule